// File: doc/BRIEF.md
# IDE Channel Memory-Mapped Register Front-End

This block sits between a simple single-cycle register bus and the internals of one IDE channel. It takes a byte address inside a 4 KiB window, derives a register index by dropping the low four address bits, and checks the access width against what that register allows. Accesses that pass are turned into one-cycle read or write strobes toward the drive logic: the data port, the seven task-file registers and the shared status/device-control register. The drive logic itself lives elsewhere and answers reads combinationally in the strobe cycle.

Two registers are held locally. One is a free 32-bit timing word that software programs for the channel. The other is an interrupt state word. Its top bit records the DMA completion interrupt and stays set until software writes a one to it. The bit below mirrors the disk interrupt. Both interrupt inputs are also passed straight to their own output pins for the system interrupt controller. Reads are answered on the cycle after the request. Any read the block does not recognise returns all ones.

Top module: `ide_mmio_frontend`

## Requirements
- R1: The register index is the request address shifted right by 4, so the low four address bits never change which register is reached (for example, address 0x20C reaches the timing register).
- R2: A data-port read (index 0) raises `drv_data_rd` for one cycle. `req_size` holds the byte count. With a size of 1, the response is bits 7:0 of the drive word, zero-extended. With a size of 2, it is bits 15:0, zero-extended. With a size of 4, it is all 32 bits. `drv_data_wide` is 1 only for the 4-byte size.
- R3: A data-port write of size 2 or 4 raises `drv_data_wr`, with `drv_data_wide` set only for size 4, and passes `req_wdata` on `drv_data_wdata`. A 1-byte data-port write raises no strobe.
- R4: Indices 1 to 7 reach the task-file registers, and only 1-byte accesses are accepted. `drv_tf_idx` carries the index. A read returns the task-file byte zero-extended. A write passes `req_wdata[7:0]`.
- R5: Indices 8 and 22 (0x16) both reach the same status/control register, 1-byte only. A read raises `drv_stat_rd` and returns the status byte zero-extended. A write raises `drv_ctl_wr` with `req_wdata[7:0]`.
- R6: Index 32 (0x20) is a 32-bit timing register. A 4-byte write stores the full word. A 4-byte read returns it.
- R7: Index 48 (0x30) is the interrupt state word, and only 4-byte reads return it. When the DMA line changes level, bit 31 takes the new level from the next cycle. Bit 30 does the same for the disk line. Bits 29:0 always read zero.
- R8: A 4-byte write to index 48 with `req_wdata[31]` set clears bit 31, even while the DMA line stays high. Writing with bit 31 at zero leaves the word unchanged. When a DMA line change and a clear arrive in the same cycle, the line change wins.
- R9: `dma_irq_out` follows `irq_dma_in` and `disk_irq_out` follows `irq_disk_in` at all times.
- R10: A read of an unmapped index, or with a size the register does not allow (including size codes 0, 3 and 5 to 7), returns 0xFFFFFFFF and raises no drive strobe.
- R11: A write of a disallowed size raises no strobe and changes neither the timing nor the interrupt state register.
- R12: `rsp_valid` is high exactly in the cycle after a read request and low after writes and idle cycles. `rsp_rdata` is registered in that same cycle.
- R13: Reset clears the timing register, the interrupt state word and `rsp_valid`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Access request this cycle |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 12 | Byte address inside the window |
| req_size | input | 3 | Access width in bytes (1, 2 or 4) |
| req_wdata | input | 32 | Write data, little-endian |
| rsp_valid | output | 1 | Read response valid |
| rsp_rdata | output | 32 | Read response data |
| drv_data_rd | output | 1 | Data-port read strobe |
| drv_data_wr | output | 1 | Data-port write strobe |
| drv_data_wide | output | 1 | Data-port access is 32-bit |
| drv_data_wdata | output | 32 | Data-port write data |
| drv_data_rdata | input | 32 | Data-port read data from drive |
| drv_tf_rd | output | 1 | Task-file read strobe |
| drv_tf_wr | output | 1 | Task-file write strobe |
| drv_tf_idx | output | 3 | Task-file register select (1 to 7) |
| drv_tf_wdata | output | 8 | Task-file write byte |
| drv_tf_rdata | input | 8 | Task-file read byte from drive |
| drv_stat_rd | output | 1 | Status read strobe |
| drv_ctl_wr | output | 1 | Device-control write strobe |
| drv_ctl_wdata | output | 8 | Device-control write byte |
| drv_stat_rdata | input | 8 | Status byte from drive |
| irq_dma_in | input | 1 | DMA interrupt level |
| irq_disk_in | input | 1 | Disk interrupt level |
| dma_irq_out | output | 1 | DMA interrupt to system |
| disk_irq_out | output | 1 | Disk interrupt to system |

## Verification
The hardest state to reach from the ports is a cleared bit 31 while the DMA line is still high. The bit is only set again by a fresh level change. The stimulus raises the DMA and disk lines, issues the clearing write while both lines stay high, and reads back a word with only bit 30 set. It then drops and raises the DMA line to re-arm bit 31, and shows that a write with bit 31 at zero and a 2-byte write both leave it set. Size codes that no register accepts are also sent to the data port and the timing register, to confirm that no strobe escapes.

// File: rtl/ide_fe_pkg.sv
package ide_fe_pkg;

  localparam int unsigned FE_DW = 32;

  typedef enum logic [2:0] {
    RG_NONE,
    RG_DATA,
    RG_TASK,
    RG_STAT,
    RG_TIMING,
    RG_IRQ
  } region_e;

  localparam logic [2:0] SZ_B = 3'd1;
  localparam logic [2:0] SZ_H = 3'd2;
  localparam logic [2:0] SZ_W = 3'd4;

  localparam logic [31:0] IX_DATA   = 32'd0;
  localparam logic [31:0] IX_TF_LO  = 32'd1;
  localparam logic [31:0] IX_TF_HI  = 32'd7;
  localparam logic [31:0] IX_STAT_A = 32'd8;
  localparam logic [31:0] IX_STAT_B = 32'd22;
  localparam logic [31:0] IX_TIMING = 32'd32;
  localparam logic [31:0] IX_IRQ    = 32'd48;

  function automatic region_e fe_region(input logic [31:0] idx);
    if (idx == IX_DATA) return RG_DATA;
    if (idx >= IX_TF_LO && idx <= IX_TF_HI) return RG_TASK;
    if (idx == IX_STAT_A || idx == IX_STAT_B) return RG_STAT;
    if (idx == IX_TIMING) return RG_TIMING;
    if (idx == IX_IRQ) return RG_IRQ;
    return RG_NONE;
  endfunction

  function automatic logic fe_size_ok(input region_e rg, input logic wr,
                                      input logic [2:0] sz);
    case (rg)
      RG_DATA:   return (sz == SZ_H) || (sz == SZ_W) || (!wr && sz == SZ_B);
      RG_TASK:   return sz == SZ_B;
      RG_STAT:   return sz == SZ_B;
      RG_TIMING: return sz == SZ_W;
      RG_IRQ:    return sz == SZ_W;
      default:   return 1'b0;
    endcase
  endfunction

  function automatic logic [FE_DW-1:0] fe_data_shape(input logic [2:0] sz,
                                                     input logic [FE_DW-1:0] raw);
    if (sz == SZ_B) return {{(FE_DW-8){1'b0}}, raw[7:0]};
    if (sz == SZ_H) return {{(FE_DW-16){1'b0}}, raw[15:0]};
    return raw;
  endfunction

endpackage

// File: rtl/ide_fe_decode.sv
module ide_fe_decode
  import ide_fe_pkg::*;
#(
  parameter int unsigned ADDR_W      = 12,
  parameter int unsigned STRIDE_LOG2 = 4,
  parameter int unsigned TFSEL_W     = 3
) (
  input  logic              req_valid,
  input  logic              req_write,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [2:0]        req_size,
  output region_e           rg,
  output logic              hit,
  output logic [TFSEL_W-1:0] tf_sel
);
  localparam int unsigned IDX_W = ADDR_W - STRIDE_LOG2;

  logic [IDX_W-1:0] idx;
  logic             unused_lo;

  assign idx       = req_addr[ADDR_W-1:STRIDE_LOG2];
  assign unused_lo = ^req_addr[STRIDE_LOG2-1:0];
  assign rg        = fe_region(32'(idx));
  assign hit       = req_valid && fe_size_ok(rg, req_write, req_size);
  assign tf_sel    = idx[TFSEL_W-1:0];
endmodule

// File: rtl/ide_fe_timing.sv
module ide_fe_timing #(
  parameter int unsigned DW = 32
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          we,
  input  logic [DW-1:0] wdata,
  output logic [DW-1:0] q
);
  always_ff @(posedge clk) begin
    if (!rst_n)  q <= '0;
    else if (we) q <= wdata;
  end
endmodule

// File: rtl/ide_fe_irqstat.sv
module ide_fe_irqstat #(
  parameter int unsigned DW       = 32,
  parameter int unsigned N_LINES  = 2,
  parameter int unsigned CLR_LINE = 0
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [N_LINES-1:0] lines,
  input  logic               clr,
  output logic [N_LINES-1:0] line_chg,
  output logic [DW-1:0]      q
);
  logic [N_LINES-1:0] lvl_q;
  logic [N_LINES-1:0] state_q;

  always_ff @(posedge clk) begin
    if (!rst_n) lvl_q <= '0;
    else        lvl_q <= lines;
  end

  assign line_chg = lines ^ lvl_q;

  for (genvar n = 0; n < N_LINES; n++) begin : g_line
    if (n == CLR_LINE) begin : g_clearable
      always_ff @(posedge clk) begin
        if (!rst_n)           state_q[n] <= 1'b0;
        else if (line_chg[n]) state_q[n] <= lines[n];
        else if (clr)         state_q[n] <= 1'b0;
      end
    end else begin : g_mirror
      always_ff @(posedge clk) begin
        if (!rst_n)           state_q[n] <= 1'b0;
        else if (line_chg[n]) state_q[n] <= lines[n];
      end
    end
  end

  always_comb begin
    q = '0;
    for (int n = 0; n < N_LINES; n++) q[DW-1-n] = state_q[n];
  end
endmodule

// File: rtl/ide_fe_rdmux.sv
module ide_fe_rdmux
  import ide_fe_pkg::*;
#(
  parameter int unsigned DW   = 32,
  parameter int unsigned TF_W = 8
) (
  input  region_e         rg,
  input  logic            hit,
  input  logic [2:0]      req_size,
  input  logic [DW-1:0]   data_raw,
  input  logic [TF_W-1:0] tf_raw,
  input  logic [TF_W-1:0] stat_raw,
  input  logic [DW-1:0]   timing_q,
  input  logic [DW-1:0]   irq_q,
  output logic [DW-1:0]   rdata
);
  always_comb begin
    rdata = '1;
    if (hit) begin
      case (rg)
        RG_DATA:   rdata = fe_data_shape(req_size, data_raw);
        RG_TASK:   rdata = {{(DW-TF_W){1'b0}}, tf_raw};
        RG_STAT:   rdata = {{(DW-TF_W){1'b0}}, stat_raw};
        RG_TIMING: rdata = timing_q;
        RG_IRQ:    rdata = irq_q;
        default:   rdata = '1;
      endcase
    end
  end
endmodule

// File: rtl/ide_mmio_frontend.sv
module ide_mmio_frontend
  import ide_fe_pkg::*;
#(
  parameter int unsigned ADDR_W      = 12,
  parameter int unsigned STRIDE_LOG2 = 4,
  parameter int unsigned TF_W        = 8,
  parameter int unsigned TFSEL_W     = 3
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               req_valid,
  input  logic               req_write,
  input  logic [ADDR_W-1:0]  req_addr,
  input  logic [2:0]         req_size,
  input  logic [FE_DW-1:0]   req_wdata,
  output logic               rsp_valid,
  output logic [FE_DW-1:0]   rsp_rdata,
  output logic               drv_data_rd,
  output logic               drv_data_wr,
  output logic               drv_data_wide,
  output logic [FE_DW-1:0]   drv_data_wdata,
  input  logic [FE_DW-1:0]   drv_data_rdata,
  output logic               drv_tf_rd,
  output logic               drv_tf_wr,
  output logic [TFSEL_W-1:0] drv_tf_idx,
  output logic [TF_W-1:0]    drv_tf_wdata,
  input  logic [TF_W-1:0]    drv_tf_rdata,
  output logic               drv_stat_rd,
  output logic               drv_ctl_wr,
  output logic [TF_W-1:0]    drv_ctl_wdata,
  input  logic [TF_W-1:0]    drv_stat_rdata,
  input  logic               irq_dma_in,
  input  logic               irq_disk_in,
  output logic               dma_irq_out,
  output logic               disk_irq_out
);
  localparam int unsigned N_LINES = 2;
  localparam int unsigned DMA_LN  = 0;

  region_e            acc_rg;
  logic               acc_hit;
  logic               rd_hit;
  logic               wr_hit;
  logic               tim_we;
  logic               irq_clr;
  logic [FE_DW-1:0]   timing_q;
  logic [FE_DW-1:0]   irq_q;
  logic [N_LINES-1:0] line_chg;
  logic [FE_DW-1:0]   rd_word;

  ide_fe_decode #(
    .ADDR_W(ADDR_W), .STRIDE_LOG2(STRIDE_LOG2), .TFSEL_W(TFSEL_W)
  ) u_dec (
    .req_valid(req_valid), .req_write(req_write), .req_addr(req_addr),
    .req_size(req_size), .rg(acc_rg), .hit(acc_hit), .tf_sel(drv_tf_idx)
  );

  assign rd_hit = acc_hit && !req_write;
  assign wr_hit = acc_hit && req_write;

  assign drv_data_rd    = rd_hit && acc_rg == RG_DATA;
  assign drv_data_wr    = wr_hit && acc_rg == RG_DATA;
  assign drv_data_wide  = req_size == SZ_W;
  assign drv_data_wdata = req_wdata;
  assign drv_tf_rd      = rd_hit && acc_rg == RG_TASK;
  assign drv_tf_wr      = wr_hit && acc_rg == RG_TASK;
  assign drv_tf_wdata   = req_wdata[TF_W-1:0];
  assign drv_stat_rd    = rd_hit && acc_rg == RG_STAT;
  assign drv_ctl_wr     = wr_hit && acc_rg == RG_STAT;
  assign drv_ctl_wdata  = req_wdata[TF_W-1:0];

  assign tim_we  = wr_hit && acc_rg == RG_TIMING;
  assign irq_clr = wr_hit && acc_rg == RG_IRQ && req_wdata[FE_DW-1];

  ide_fe_timing #(.DW(FE_DW)) u_tim (
    .clk(clk), .rst_n(rst_n), .we(tim_we), .wdata(req_wdata), .q(timing_q)
  );

  ide_fe_irqstat #(.DW(FE_DW), .N_LINES(N_LINES), .CLR_LINE(DMA_LN)) u_irq (
    .clk(clk), .rst_n(rst_n), .lines({irq_disk_in, irq_dma_in}),
    .clr(irq_clr), .line_chg(line_chg), .q(irq_q)
  );

  assign dma_irq_out  = irq_dma_in;
  assign disk_irq_out = irq_disk_in;

  ide_fe_rdmux #(.DW(FE_DW), .TF_W(TF_W)) u_mux (
    .rg(acc_rg), .hit(acc_hit), .req_size(req_size),
    .data_raw(drv_data_rdata), .tf_raw(drv_tf_rdata), .stat_raw(drv_stat_rdata),
    .timing_q(timing_q), .irq_q(irq_q), .rdata(rd_word)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rsp_valid <= 1'b0;
      rsp_rdata <= '0;
    end else begin
      rsp_valid <= req_valid && !req_write;
      if (req_valid && !req_write) rsp_rdata <= rd_word;
    end
  end
endmodule

// File: rtl/ide_fe_checker.sv
module ide_fe_checker (
  input logic        clk,
  input logic        rst_n,
  input logic        req_valid,
  input logic        req_write,
  input logic [2:0]  req_size,
  input logic        acc_hit,
  input logic        rsp_valid,
  input logic [31:0] rsp_rdata,
  input logic        drv_data_rd,
  input logic        drv_data_wr,
  input logic        drv_tf_rd,
  input logic        drv_tf_wr,
  input logic        drv_stat_rd,
  input logic        drv_ctl_wr,
  input logic        tim_we,
  input logic [31:0] timing_q,
  input logic        irq_clr,
  input logic [31:0] irq_q,
  input logic [1:0]  line_chg,
  input logic        irq_dma_in
);
  // R12: response follows every read by one cycle
  a_r12_rsp_after_read: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && !req_write) |=> rsp_valid);

  // R12: no response without a read
  a_r12_quiet_otherwise: assert property (@(posedge clk) disable iff (!rst_n)
    !(req_valid && !req_write) |=> !rsp_valid);

  // R10: rejected reads answer all ones
  a_r10_miss_all_ones: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && !req_write && !acc_hit) |=> rsp_rdata == 32'hFFFF_FFFF);

  // R3: byte writes never strobe the data port
  a_r3_no_byte_data_wr: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_write && req_size == 3'd1) |-> !drv_data_wr);

  // R11: timing word holds without an accepted write
  a_r11_timing_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !tim_we |=> $stable(timing_q));

  // R7: DMA bit takes the new line level
  a_r7_dma_bit_follows: assert property (@(posedge clk) disable iff (!rst_n)
    line_chg[0] |=> irq_q[31] == $past(irq_dma_in));

  // R7: spare bits stay zero
  a_r7_spare_zero: assert property (@(posedge clk) disable iff (!rst_n)
    irq_q[29:0] == 30'd0);

  // R8: clear wins when the line is quiet
  a_r8_clear_bit31: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_clr && !line_chg[0]) |=> !irq_q[31]);

  // R4/R5/R2: at most one drive strobe at a time
  a_r4_single_strobe: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({drv_data_rd, drv_data_wr, drv_tf_rd, drv_tf_wr, drv_stat_rd, drv_ctl_wr}));
endmodule

bind ide_mmio_frontend ide_fe_checker u_chk (
  .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_write(req_write),
  .req_size(req_size), .acc_hit(acc_hit), .rsp_valid(rsp_valid),
  .rsp_rdata(rsp_rdata), .drv_data_rd(drv_data_rd), .drv_data_wr(drv_data_wr),
  .drv_tf_rd(drv_tf_rd), .drv_tf_wr(drv_tf_wr), .drv_stat_rd(drv_stat_rd),
  .drv_ctl_wr(drv_ctl_wr), .tim_we(tim_we), .timing_q(timing_q),
  .irq_clr(irq_clr), .irq_q(irq_q), .line_chg(line_chg), .irq_dma_in(irq_dma_in)
);

// File: tb/test_ide_mmio_frontend.sv
`timescale 1ns/1ps
module test_ide_mmio_frontend;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0, req_write = 1'b0;
  logic [11:0] req_addr = '0;
  logic [2:0]  req_size = '0;
  logic [31:0] req_wdata = '0;
  logic        rsp_valid;
  logic [31:0] rsp_rdata;
  logic        drv_data_rd, drv_data_wr, drv_data_wide;
  logic [31:0] drv_data_wdata;
  logic [31:0] drv_data_rdata = 32'h1234_ABCD;
  logic        drv_tf_rd, drv_tf_wr;
  logic [2:0]  drv_tf_idx;
  logic [7:0]  drv_tf_wdata, drv_tf_rdata;
  logic        drv_stat_rd, drv_ctl_wr;
  logic [7:0]  drv_ctl_wdata;
  logic [7:0]  drv_stat_rdata = 8'h58;
  logic        irq_dma_in = 1'b0, irq_disk_in = 1'b0;
  logic        dma_irq_out, disk_irq_out;

  int n_cmp = 0, n_bad = 0;
  bit done = 1'b0;

  logic [5:0]  l_strb;
  logic [2:0]  l_tfi;
  logic        l_wide, l_rv;
  logic [31:0] l_rd, l_dwd;
  logic [7:0]  l_bwd;

  assign drv_tf_rdata = 8'h50 + {5'd0, drv_tf_idx};

  always #4 clk = ~clk;

  ide_mmio_frontend i_ide_mmio_frontend (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_write(req_write),
    .req_addr(req_addr), .req_size(req_size), .req_wdata(req_wdata),
    .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata),
    .drv_data_rd(drv_data_rd), .drv_data_wr(drv_data_wr),
    .drv_data_wide(drv_data_wide), .drv_data_wdata(drv_data_wdata),
    .drv_data_rdata(drv_data_rdata), .drv_tf_rd(drv_tf_rd), .drv_tf_wr(drv_tf_wr),
    .drv_tf_idx(drv_tf_idx), .drv_tf_wdata(drv_tf_wdata), .drv_tf_rdata(drv_tf_rdata),
    .drv_stat_rd(drv_stat_rd), .drv_ctl_wr(drv_ctl_wr), .drv_ctl_wdata(drv_ctl_wdata),
    .drv_stat_rdata(drv_stat_rdata), .irq_dma_in(irq_dma_in), .irq_disk_in(irq_disk_in),
    .dma_irq_out(dma_irq_out), .disk_irq_out(disk_irq_out)
  );

  // strobe vector order: data_rd, data_wr, tf_rd, tf_wr, stat_rd, ctl_wr
  localparam logic [5:0] S_DRD = 6'b100000, S_DWR = 6'b010000, S_TRD = 6'b001000,
                         S_TWR = 6'b000100, S_SRD = 6'b000010, S_CWR = 6'b000001;

  task automatic chk(input string tag, input logic [31:0] got, input logic [31:0] exp);
    n_cmp++;
    if (got !== exp) begin
      n_bad++;
      $display("FAIL %s: got %h expected %h", tag, got, exp);
    end
  endtask

  task automatic snap();
    l_strb = {drv_data_rd, drv_data_wr, drv_tf_rd, drv_tf_wr, drv_stat_rd, drv_ctl_wr};
    l_tfi  = drv_tf_idx;
    l_wide = drv_data_wide;
    l_dwd  = drv_data_wdata;
    l_bwd  = drv_tf_wdata;
  endtask

  task automatic bus_rd(input logic [11:0] a, input logic [2:0] s);
    @(negedge clk);
    req_valid = 1'b1; req_write = 1'b0; req_addr = a; req_size = s;
    #1 snap();
    @(posedge clk);
    #1 l_rd = rsp_rdata; l_rv = rsp_valid;
    req_valid = 1'b0;
  endtask

  task automatic bus_wr(input logic [11:0] a, input logic [2:0] s, input logic [31:0] d);
    @(negedge clk);
    req_valid = 1'b1; req_write = 1'b1; req_addr = a; req_size = s; req_wdata = d;
    #1 snap();
    @(posedge clk);
    #1 l_rv = rsp_valid;
    req_valid = 1'b0;
  endtask

  task automatic set_lines(input logic dma, input logic disk);
    @(negedge clk);
    irq_dma_in = dma; irq_disk_in = disk;
    @(posedge clk);
  endtask

  task automatic t_reset_state();
    chk("R13 rsp_valid after reset", {31'd0, rsp_valid}, 32'd0);
    bus_rd(12'h200, 3'd4);
    chk("R13 timing after reset", l_rd, 32'd0);
    chk("R12 rsp_valid on read", {31'd0, l_rv}, 32'd1);
    bus_rd(12'h300, 3'd4);
    chk("R13 irq word after reset", l_rd, 32'd0);
  endtask

  task automatic t_data_port();
    bus_rd(12'h000, 3'd1);
    chk("R2 byte read data", l_rd, 32'h0000_00CD);
    chk("R2 byte read strobe", {26'd0, l_strb}, {26'd0, S_DRD});
    chk("R2 byte read narrow", {31'd0, l_wide}, 32'd0);
    bus_rd(12'h004, 3'd2);
    chk("R2 half read data", l_rd, 32'h0000_ABCD);
    bus_rd(12'h000, 3'd4);
    chk("R2 word read data", l_rd, 32'h1234_ABCD);
    chk("R2 word read wide", {31'd0, l_wide}, 32'd1);
    bus_wr(12'h000, 3'd2, 32'hFFFF_5A5A);
    chk("R3 half write strobe", {26'd0, l_strb}, {26'd0, S_DWR});
    chk("R3 half write narrow", {31'd0, l_wide}, 32'd0);
    chk("R3 half write data", {16'd0, l_dwd[15:0]}, 32'h0000_5A5A);
    chk("R12 no rsp after write", {31'd0, l_rv}, 32'd0);
    bus_wr(12'h000, 3'd4, 32'hCAFE_F00D);
    chk("R3 word write wide", {31'd0, l_wide}, 32'd1);
    chk("R3 word write data", l_dwd, 32'hCAFE_F00D);
    bus_wr(12'h000, 3'd1, 32'h0000_0011);
    chk("R3 byte write ignored", {26'd0, l_strb}, 32'd0);
  endtask

  task automatic t_taskfile();
    bus_rd(12'h030, 3'd1);
    chk("R4 tf read data", l_rd, 32'h0000_0053);
    chk("R4 tf read idx", {29'd0, l_tfi}, 32'd3);
    chk("R4 tf read strobe", {26'd0, l_strb}, {26'd0, S_TRD});
    bus_wr(12'h07F, 3'd1, 32'h0000_00A7);
    chk("R4 tf write strobe", {26'd0, l_strb}, {26'd0, S_TWR});
    chk("R4 tf write idx", {29'd0, l_tfi}, 32'd7);
    chk("R4 tf write byte", {24'd0, l_bwd}, 32'h0000_00A7);
    bus_rd(12'h030, 3'd4);
    chk("R10 tf word read", l_rd, 32'hFFFF_FFFF);
    chk("R10 tf word no strobe", {26'd0, l_strb}, 32'd0);
  endtask

  task automatic t_statctl();
    bus_rd(12'h080, 3'd1);
    chk("R5 status via idx 8", l_rd, 32'h0000_0058);
    chk("R5 status strobe", {26'd0, l_strb}, {26'd0, S_SRD});
    bus_rd(12'h160, 3'd1);
    chk("R5 status via idx 22", l_rd, 32'h0000_0058);
    bus_wr(12'h160, 3'd1, 32'h0000_0002);
    chk("R5 control strobe", {26'd0, l_strb}, {26'd0, S_CWR});
    bus_rd(12'h090, 3'd1);
    chk("R10 unmapped index", l_rd, 32'hFFFF_FFFF);
    chk("R10 unmapped no strobe", {26'd0, l_strb}, 32'd0);
    bus_rd(12'h000, 3'd3);
    chk("R10 size code 3", l_rd, 32'hFFFF_FFFF);
    bus_wr(12'h000, 3'd0, 32'h1);
    chk("R11 size code 0 write", {26'd0, l_strb}, 32'd0);
  endtask

  task automatic t_timing();
    bus_wr(12'h200, 3'd4, 32'hDEAD_BEEF);
    bus_rd(12'h200, 3'd4);
    chk("R6 timing readback", l_rd, 32'hDEAD_BEEF);
    bus_wr(12'h200, 3'd1, 32'h0000_0012);
    bus_wr(12'h200, 3'd6, 32'h0000_0034);
    bus_rd(12'h20C, 3'd4);
    chk("R11 timing after bad writes", l_rd, 32'hDEAD_BEEF);
    chk("R1 alias low nibble", l_rd, 32'hDEAD_BEEF);
    bus_rd(12'h200, 3'd2);
    chk("R10 timing half read", l_rd, 32'hFFFF_FFFF);
  endtask

  task automatic t_irq();
    set_lines(1'b1, 1'b0);
    chk("R9 dma out", {31'd0, dma_irq_out}, 32'd1);
    bus_rd(12'h300, 3'd4);
    chk("R7 dma bit set", l_rd, 32'h8000_0000);
    set_lines(1'b1, 1'b1);
    chk("R9 disk out", {31'd0, disk_irq_out}, 32'd1);
    bus_rd(12'h300, 3'd4);
    chk("R7 both bits", l_rd, 32'hC000_0000);
    bus_wr(12'h300, 3'd4, 32'h8000_0000);
    bus_rd(12'h300, 3'd4);
    chk("R8 clear while line high", l_rd, 32'h4000_0000);
    set_lines(1'b0, 1'b1);
    set_lines(1'b1, 1'b1);
    bus_wr(12'h300, 3'd4, 32'h7FFF_FFFF);
    bus_rd(12'h300, 3'd4);
    chk("R8 bit31 zero no clear", l_rd, 32'hC000_0000);
    bus_wr(12'h300, 3'd2, 32'h8000_0000);
    bus_rd(12'h300, 3'd4);
    chk("R11 half write no clear", l_rd, 32'hC000_0000);
    bus_rd(12'h300, 3'd2);
    chk("R10 irq half read", l_rd, 32'hFFFF_FFFF);
    // clear and a line change in the same cycle: line change wins
    bus_wr(12'h300, 3'd4, 32'h8000_0000);
    @(negedge clk);
    irq_dma_in = 1'b0;
    @(negedge clk);
    irq_dma_in = 1'b1;
    req_valid = 1'b1; req_write = 1'b1; req_addr = 12'h300; req_size = 3'd4;
    req_wdata = 32'h8000_0000;
    @(posedge clk);
    #1 req_valid = 1'b0;
    bus_rd(12'h300, 3'd4);
    chk("R8 line change beats clear", l_rd, 32'hC000_0000);
    set_lines(1'b0, 1'b0);
    chk("R9 outputs low", {30'd0, disk_irq_out, dma_irq_out}, 32'd0);
    bus_rd(12'h300, 3'd4);
    chk("R7 bits follow low", l_rd, 32'h0000_0000);
  endtask

  task automatic t_reset_again();
    bus_wr(12'h200, 3'd4, 32'h0BAD_CAFE);
    @(negedge clk); rst_n = 1'b0;
    repeat (2) @(posedge clk);
    @(negedge clk); rst_n = 1'b1;
    bus_rd(12'h200, 3'd4);
    chk("R13 timing cleared by reset", l_rd, 32'd0);
  endtask

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk) rst_n = 1'b1;
    t_reset_state();
    t_data_port();
    t_taskfile();
    t_statctl();
    t_timing();
    t_irq();
    t_reset_again();
    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_cmp++; n_bad++;
      $display("FAIL watchdog: run did not complete, got hang expected finish");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end
endmodule